// File: doc/BRIEF.md
# I2C Target Byte Engine

This block answers as a 7-bit-address target on an I2C bus. It runs entirely on a fast system clock, and SCL and SDA arrive through synchronisers. The bus lines are driven open-drain: each output means "pull this line low". The block finds START and STOP conditions, compares the address byte with `own_addr` and records the direction bit. It assembles received bytes in a shift register and hands them to a single software-visible byte buffer.

Whether a received byte is acknowledged depends on two status flags: a buffer-full flag that software clears by reading, and a sticky overflow flag that software must clear explicitly. For read transfers, the target holds SCL low after the address acknowledge and after each acknowledged data byte. The hold lasts until software has written the next transmit byte and pulsed a clock-release input. A per-byte interrupt flag marks every byte the target took part in.

Top module: `i2c_target_engine`

## Requirements
- R1: START (SDA falling while SCL is high) begins a new address byte from any state, including in the middle of a byte or transfer. STOP (SDA rising while SCL is high) releases both lines and returns the block to waiting for START. A byte cut short by either condition raises no interrupt.
- R2: When the 7 address bits, received MSB first, equal `own_addr`, the whole address byte is offered to the buffer like a data byte, and `rw_flag` takes bit 0 of that byte. On a mismatch SDA is never pulled and no interrupt is raised, and the bus is ignored until the next START.
- R3: `irq_flag` is set once for every received byte that was addressed to the block, at the falling SCL edge after bit 8. It is set for every transmitted byte at the falling edge of the ninth clock. It stays set until `sw_irq_clr`.
- R4: A received byte that completes with buffer-full=0 and overflow=0 is copied into the buffer, sets buffer-full, and is ACKed: SDA is pulled low during the ninth clock.
- R5: A received byte that completes with buffer-full=1 leaves the buffer unchanged, is not ACKed, and sets overflow, whatever overflow was before.
- R6: A received byte that completes with buffer-full=0 and overflow=1 is copied into the buffer and sets buffer-full, but is not ACKed.
- R7: `sw_rx_rd` clears buffer-full. Overflow clears only on `sw_ovf_clr`.
- R8: After an ACKed read address, the block pulls SCL low once the ninth clock falls. It keeps SCL low until `sw_clk_release`. `sw_tx_wr` loads both the buffer and the transmit shifter.
- R9: Transmit bits leave MSB first. SDA is changed only while SCL is low.
- R10: The controller's acknowledge is sampled on the ninth rising SCL edge of a transmitted byte. An ACK (SDA low) leads to another SCL hold as in R8. A NACK (SDA high) releases the bus, and the block then drives nothing until the next START.
- R11: Received bits are sampled on rising SCL edges, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| sw_tx_wr | input | 1 | Pulse: write `sw_tx_data` to buffer and transmit shifter |
| sw_tx_data | input | 8 | Transmit byte |
| sw_rx_rd | input | 1 | Pulse: buffer read, clears buffer-full |
| sw_clk_release | input | 1 | Pulse: end the SCL hold |
| sw_irq_clr | input | 1 | Pulse: clear the interrupt flag |
| sw_ovf_clr | input | 1 | Pulse: clear the overflow flag |
| buf_data | output | 8 | Byte buffer contents |
| buf_full | output | 1 | Buffer-full flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_flag | output | 1 | Per-byte interrupt flag |
| rw_flag | output | 1 | Direction bit of the last matched address |

## Verification
Several properties are checked on every cycle. The stickiness of the interrupt and overflow flags is one. Others are that a completed byte never disturbs a full buffer, that a clean byte always lands in the buffer, that STOP always frees both lines, that the SCL hold persists until released, and that SDA only moves while SCL is low. The following are shown only by the bench's bus scenarios: the address sweep with single-bit mismatches, the ACK pattern across all three flag combinations, MSB-first data values in both directions, recovery after an aborted byte and a repeated START, and silence after a read NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RX_DATA,
      ST_RX_ACK,
      ST_RD_ACK,
      ST_TX_HOLD,
      ST_TX_DATA,
      ST_TX_ACK
   } tgt_state_t;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              irq_set,
   input  logic              tx_wr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              rx_rd,
   input  logic              irq_clr,
   input  logic              ovf_clr,
   output logic              ack_ok,
   output logic [BYTE_W-1:0] buf_q,
   output logic              bf_q,
   output logic              ovf_q,
   output logic              irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
         bf_q  <= 1'b0;
         ovf_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (commit) begin
            if (bf_q) begin
               ovf_q <= 1'b1;
            end else begin
               buf_q <= rx_byte;
               bf_q  <= 1'b1;
            end
         end else begin
            if (tx_wr) buf_q <= tx_data;
            if (rx_rd) bf_q  <= 1'b0;
         end
         if (ovf_clr && !(commit && bf_q)) ovf_q <= 1'b0;
         if (irq_set)      irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
      end
   end

   assign ack_ok = ~bf_q & ~ovf_q;

   assert_full_keeps_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && bf_q) |=> ($stable(buf_q) && ovf_q));
   assert_clean_byte_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !bf_q) |=> (bf_q && buf_q == $past(rx_byte)));
   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q);
   assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              ack_ok,
   input  logic              tx_wr,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              sw_release,
   output logic              commit,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              irq_set,
   output logic              rw_q,
   output logic              scl_pull,
   output logic              sda_pull
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   tgt_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] rxsh, txsh;
   logic              ckp_q, mnack_q;
   logic              bus_evt, addr_hit, rx_phase;

   assign bus_evt  = start_ev | stop_ev;
   assign addr_hit = (rxsh[BYTE_W-1:1] == own_addr);
   assign rx_phase = (st == ST_ADDR && addr_hit) || (st == ST_RX_DATA);
   assign commit   = !bus_evt && rx_phase && scl_fall && (cnt == CNT_FULL);
   assign irq_set  = commit || (!bus_evt && st == ST_TX_ACK && scl_fall);
   assign rx_byte  = rxsh;
   assign scl_pull = (st == ST_TX_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         rxsh     <= '0;
         txsh     <= '0;
         sda_pull <= 1'b0;
         ckp_q    <= 1'b0;
         mnack_q  <= 1'b0;
         rw_q     <= 1'b0;
      end else begin
         if (tx_wr)      txsh  <= tx_data;
         if (sw_release) ckp_q <= 1'b1;
         if (start_ev) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_ev) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_RX_DATA: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     rxsh <= {rxsh[BYTE_W-2:0], sda_lvl};
                     cnt  <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (st == ST_ADDR && !addr_hit) begin
                        st <= ST_IDLE;
                     end else begin
                        sda_pull <= ack_ok;
                        if (st == ST_ADDR) begin
                           rw_q <= rxsh[0];
                           if (!ack_ok)      st <= ST_IDLE;
                           else if (rxsh[0]) st <= ST_RD_ACK;
                           else              st <= ST_RX_ACK;
                        end else begin
                           st <= ST_RX_ACK;
                        end
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st       <= ST_RX_DATA;
                     cnt      <= '0;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st       <= ST_TX_HOLD;
                     ckp_q    <= 1'b0;
                  end
               end
               ST_TX_HOLD: begin
                  if (ckp_q) begin
                     st       <= ST_TX_DATA;
                     cnt      <= '0;
                     sda_pull <= ~txsh[BYTE_W-1];
                  end
               end
               ST_TX_DATA: begin
                  if (scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        sda_pull <= 1'b0;
                        st       <= ST_TX_ACK;
                     end else begin
                        txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~txsh[BYTE_W-2];
                        cnt      <= cnt + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) mnack_q <= sda_lvl;
                  if (scl_fall) begin
                     if (mnack_q) begin
                        st <= ST_IDLE;
                     end else begin
                        st    <= ST_TX_HOLD;
                        ckp_q <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_stop_frees_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!sda_pull && !scl_pull));
   assert_hold_until_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pull && !ckp_q && !sw_release) |=> scl_pull);
   assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_pull) && !$past(bus_evt)) |-> !$past(scl_lvl));
   assert_mismatch_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && scl_fall && cnt == CNT_FULL && !addr_hit && !bus_evt) |=> !sda_pull);
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull,
   input  logic              sw_tx_wr,
   input  logic [BYTE_W-1:0] sw_tx_data,
   input  logic              sw_rx_rd,
   input  logic              sw_clk_release,
   input  logic              sw_irq_clr,
   input  logic              sw_ovf_clr,
   output logic [BYTE_W-1:0] buf_data,
   output logic              buf_full,
   output logic              ovf_flag,
   output logic              irq_flag,
   output logic              rw_flag
);
   logic [1:0] raw_lines, sync_lines;
   assign raw_lines = {sda_in, scl_in};

   generate
      for (genvar l = 0; l < 2; l++) begin : g_line_sync
         i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[l]),
            .q     (sync_lines[l])
         );
      end
   endgenerate

   logic scl_rise, scl_fall, start_ev, stop_ev;
   logic commit, irq_set, ack_ok;
   logic [BYTE_W-1:0] rx_byte;

   i2c_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (sync_lines[0]),
      .sda_s    (sync_lines[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2c_tgt_core u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .own_addr   (own_addr),
      .scl_lvl    (sync_lines[0]),
      .sda_lvl    (sync_lines[1]),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_ev   (start_ev),
      .stop_ev    (stop_ev),
      .ack_ok     (ack_ok),
      .tx_wr      (sw_tx_wr),
      .tx_data    (sw_tx_data),
      .sw_release (sw_clk_release),
      .commit     (commit),
      .rx_byte    (rx_byte),
      .irq_set    (irq_set),
      .rw_q       (rw_flag),
      .scl_pull   (scl_pull),
      .sda_pull   (sda_pull)
   );

   i2c_tgt_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .rx_byte (rx_byte),
      .irq_set (irq_set),
      .tx_wr   (sw_tx_wr),
      .tx_data (sw_tx_data),
      .rx_rd   (sw_rx_rd),
      .irq_clr (sw_irq_clr),
      .ovf_clr (sw_ovf_clr),
      .ack_ok  (ack_ok),
      .buf_q   (buf_data),
      .bf_q    (buf_full),
      .ovf_q   (ovf_flag),
      .irq_q   (irq_flag)
   );
endmodule

// File: tb/sim_i2c_target_engine.sv
module sim_i2c_target_engine;
   localparam int Q = 10;
   localparam logic [6:0] MY_ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_ln, sda_ln, scl_pull, sda_pull;
   logic sw_tx_wr = 1'b0, sw_rx_rd = 1'b0, sw_clk_release = 1'b0;
   logic sw_irq_clr = 1'b0, sw_ovf_clr = 1'b0;
   logic [7:0] sw_tx_data = '0;
   logic [7:0] buf_data;
   logic buf_full, ovf_flag, irq_flag, rw_flag;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   assign scl_ln = m_scl & ~scl_pull;
   assign sda_ln = m_sda & ~sda_pull;

   i2c_target_engine u0 (
      .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR),
      .scl_in(scl_ln), .sda_in(sda_ln),
      .scl_pull(scl_pull), .sda_pull(sda_pull),
      .sw_tx_wr(sw_tx_wr), .sw_tx_data(sw_tx_data), .sw_rx_rd(sw_rx_rd),
      .sw_clk_release(sw_clk_release), .sw_irq_clr(sw_irq_clr), .sw_ovf_clr(sw_ovf_clr),
      .buf_data(buf_data), .buf_full(buf_full), .ovf_flag(ovf_flag),
      .irq_flag(irq_flag), .rw_flag(rw_flag)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; wt(Q);
      m_scl = 1'b1;
      while (!scl_ln) wt(1);
      wt(2 * Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1;
      while (!scl_ln) wt(1);
      wt(Q); b = sda_ln; wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(2 * Q);
      m_sda = 1'b0; wt(2 * Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(2 * Q);
      m_sda = 1'b1; wt(2 * Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic nb;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(nb);
      ack = ~nb;
   endtask

   task automatic rd_byte(output logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) bit_in(b[i]);
      bit_out(~ack);
   endtask

   task automatic pulse_rd();      sw_rx_rd = 1'b1;       wt(1); sw_rx_rd = 1'b0;       wt(2); endtask
   task automatic pulse_irq_clr(); sw_irq_clr = 1'b1;     wt(1); sw_irq_clr = 1'b0;     wt(2); endtask
   task automatic pulse_ovf_clr(); sw_ovf_clr = 1'b1;     wt(1); sw_ovf_clr = 1'b0;     wt(2); endtask
   task automatic pulse_release(); sw_clk_release = 1'b1; wt(1); sw_clk_release = 1'b0; wt(2); endtask
   task automatic tx_load(input logic [7:0] d);
      sw_tx_data = d; sw_tx_wr = 1'b1; wt(1); sw_tx_wr = 1'b0; wt(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] d;
      logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h7E};
      wt(5); rst_n = 1'b1; wt(5);

      // R1 reset state
      chk("R1 reset scl_pull", scl_pull, 0);
      chk("R1 reset sda_pull", sda_pull, 0);
      chk("R1 reset flags", {buf_full, ovf_flag, irq_flag}, 0);

      // R2 sweep of single-bit address mismatches
      for (int k = 0; k < 7; k++) begin
         bus_start();
         wr_byte({MY_ADDR ^ 7'(1 << k), 1'b0}, ack);
         chk("R2 mismatch addr nack", ack, 0);
         wr_byte(8'h5A, ack);
         chk("R2 ignored data nack", ack, 0);
         chk("R2 mismatch no irq", irq_flag, 0);
         chk("R2 mismatch buffer empty", buf_full, 0);
         bus_stop();
      end

      // R2 R3 R4 matching write address
      bus_start();
      wr_byte({MY_ADDR, 1'b0}, ack);
      chk("R2 match ack", ack, 1);
      chk("R2 address in buffer", buf_data, 8'h54);
      chk("R2 rw cleared", rw_flag, 0);
      chk("R4 buffer full", buf_full, 1);
      chk("R3 irq after address", irq_flag, 1);
      wt(40);
      chk("R3 irq stays set", irq_flag, 1);
      pulse_irq_clr();
      chk("R3 irq cleared by software", irq_flag, 0);
      pulse_rd();
      chk("R7 read clears full", buf_full, 0);

      // R4 R11 data pattern sweep
      foreach (pats[i]) begin
         wr_byte(pats[i], ack);
         chk("R4 clean byte ack", ack, 1);
         chk("R11 byte value", buf_data, pats[i]);
         chk("R3 irq per byte", irq_flag, 1);
         pulse_irq_clr();
         pulse_rd();
      end

      // R5 R6 R7 overflow handling
      wr_byte(8'h11, ack);
      chk("R4 ack before overflow", ack, 1);
      pulse_irq_clr();
      wr_byte(8'h22, ack);
      chk("R5 full byte nack", ack, 0);
      chk("R5 buffer unchanged", buf_data, 8'h11);
      chk("R5 overflow set", ovf_flag, 1);
      chk("R3 irq on nacked byte", irq_flag, 1);
      wr_byte(8'h33, ack);
      chk("R5 repeat nack", ack, 0);
      chk("R5 buffer still unchanged", buf_data, 8'h11);
      pulse_rd();
      chk("R7 read clears full only", buf_full, 0);
      chk("R7 overflow survives read", ovf_flag, 1);
      wr_byte(8'h44, ack);
      chk("R6 overflow nack", ack, 0);
      chk("R6 buffer updated", buf_data, 8'h44);
      chk("R6 full set", buf_full, 1);
      pulse_ovf_clr();
      chk("R7 overflow cleared", ovf_flag, 0);
      pulse_rd();
      wr_byte(8'h66, ack);
      chk("R4 ack resumes", ack, 1);
      pulse_rd(); pulse_irq_clr();
      bus_stop();
      chk("R1 stop releases sda", sda_pull, 0);
      chk("R1 stop releases scl", scl_pull, 0);

      // R1 abort mid byte
      bus_start();
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      bus_stop();
      wt(10);
      chk("R1 aborted byte no irq", irq_flag, 0);
      chk("R1 aborted byte no buffer", buf_full, 0);
      bus_start();
      wr_byte({MY_ADDR, 1'b0}, ack);
      chk("R1 fresh address after abort", ack, 1);
      pulse_rd(); pulse_irq_clr();

      // R1 repeated START into a read, R8 R9 R10
      bus_start();
      wr_byte({MY_ADDR, 1'b1}, ack);
      chk("R1 repeated start addr ack", ack, 1);
      chk("R2 rw set", rw_flag, 1);
      chk("R2 read address in buffer", buf_data, 8'h55);
      chk("R8 scl held", scl_pull, 1);
      wt(50);
      chk("R8 scl still held", scl_pull, 1);
      pulse_rd(); pulse_irq_clr();
      tx_load(8'hC6);
      chk("R8 tx write loads buffer", buf_data, 8'hC6);
      chk("R8 held after tx write", scl_pull, 1);
      pulse_release();
      chk("R8 released", scl_pull, 0);
      rd_byte(d, 1'b1);
      chk("R9 first tx byte", d, 8'hC6);
      chk("R3 irq after tx byte", irq_flag, 1);
      chk("R10 ack rearms hold", scl_pull, 1);
      pulse_irq_clr();
      tx_load(8'h3A);
      pulse_release();
      rd_byte(d, 1'b0);
      chk("R9 second tx byte", d, 8'h3A);
      wt(5);
      chk("R10 nack frees scl", scl_pull, 0);
      chk("R10 nack frees sda", sda_pull, 0);
      pulse_irq_clr();
      rd_byte(d, 1'b0);
      chk("R10 silent after nack", d, 8'hFF);
      chk("R10 no irq after nack", irq_flag, 0);
      bus_stop();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule